// File: doc/BRIEF.md
# Strided Vector Load Issue Controller

This block sits on the controller side of a four-way interleaved memory. A vector load is given to it as a base address, a stride and an element count. The block then walks the element addresses and sends one element request to the banks per cycle. The first address is the base. Each later address is the previous one plus the stride, so a stride of 1 reads consecutive words. A stride of 3 from base 1000 reads 1000, 1003, 1006 and 1009, which is one column of a row-major matrix with three columns.

Each request raises exactly one bank chip-enable, decoded from the low address bits. The remaining upper bits go out as the address inside that bank. A request waits while its target bank reports busy. A pulse on the done flag marks the cycle after the final request. The banks, the return of data and any ordering of that data are handled outside this block.

Top module: `strided_load_issuer`

## Requirements
- R1: While no load is running, `ready_o` is 1. A `start_i` seen on a clock edge with `ready_o` high captures `base_i`, `stride_i` and `count_i`, and `ready_o` goes low on the next cycle if the count is non-zero.
- R2: The k-th element request (k counted from 0) uses address `base + k*stride` modulo 2^ADDR_W. The stride is unsigned and the sum wraps.
- R3: During a request, `bank_en_o` has exactly one bit set, bit b, where b is address bits [1:0]. Outside a request, `bank_en_o` is all zeros. At no time is more than one bit set.
- R4: During a request, `row_addr_o` equals the address shifted right by two bits. Outside a request it is zero.
- R5: If `bank_busy_i[b]` is 1 for the target bank b, no request is made in that cycle and the address is held. The busy bits of other banks have no effect.
- R6: Exactly `count` requests are made. `done_o` is 1 for the single cycle that follows the last request, and `ready_o` is 1 again in that same cycle.
- R7: A `start_i` given while a load is running is ignored. The addresses and the number of requests of the running load do not change.
- R8: A start with a count of zero makes no request and pulses `done_o` in the next cycle.
- R9: After a synchronous active-low reset, `ready_o` is 1, `issue_o` is 0, `done_o` is 0 and `bank_en_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a vector load (taken only while ready_o is high) |
| base_i | input | ADDR_W | First element address |
| stride_i | input | ADDR_W | Address increment between elements |
| count_i | input | CNT_W | Number of elements |
| bank_busy_i | input | 2**BANK_BITS | Per-bank busy flags |
| ready_o | output | 1 | No load running; a start will be accepted |
| issue_o | output | 1 | An element request is made this cycle |
| bank_en_o | output | 2**BANK_BITS | One-hot bank chip-enable |
| row_addr_o | output | ADDR_W-BANK_BITS | Address inside the selected bank |
| done_o | output | 1 | One-cycle pulse after the final request |

## Verification
The assertions check four things on every cycle: at most one chip-enable is set, no enable goes to a busy bank, the address moves by exactly the stride on each request, and the address and stride stay frozen during stalls and while a start arrives in mid-load. Some properties need a whole load to observe, and only the bench's scenarios show them. These are that the first address equals the base, that exactly the requested number of elements is issued, that the done pulse falls in the correct cycle, and that zero-length loads and address wrap-around behave as stated. The bench compares every request against arithmetic expectations across a sweep of bases, strides, counts and busy patterns.

// File: rtl/strided_issue_pkg.sv
// Shared types and defaults for the strided vector load issuer.
// Assumes: nothing beyond IEEE 1800-2017.
package strided_issue_pkg;
    localparam int unsigned DEF_ADDR_W    = 16;
    localparam int unsigned DEF_BANK_BITS = 2;
    localparam int unsigned DEF_CNT_W     = 8;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/sv_addr_walker.sv
// Holds the running element address and the stride of the current load.
// Loads base and stride on load_i; adds the stride on every step_i.
// Assumes: load_i and step_i are never high in the same cycle.
module sv_addr_walker #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] stride_o
);
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] stride_q;

    // Capture on load, otherwise advance by the stride on each issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            stride_q <= '0;
        end else if (load_i) begin
            addr_q   <= base_i;
            stride_q <= stride_i;
        end else if (step_i) begin
            addr_q   <= addr_q + stride_q;
        end
    end

    assign addr_o   = addr_q;
    assign stride_o = stride_q;
endmodule

// File: rtl/sv_bank_decoder.sv
// Decodes a bank number into a one-hot chip-enable, gated by enable_i.
// Assumes: NBANKS = 2**SEL_W.
module sv_bank_decoder #(
    parameter int unsigned SEL_W = 2,
    localparam int unsigned NBANKS = 1 << SEL_W
) (
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              enable_i,
    output logic [NBANKS-1:0] onehot_o
);
    genvar gi;
    generate
        for (gi = 0; gi < NBANKS; gi++) begin : g_line
            // One output line per bank: high only when its number is selected.
            assign onehot_o[gi] = enable_i && (sel_i == SEL_W'(gi));
        end
    endgenerate
endmodule

// File: rtl/sv_issue_sequencer.sv
// Control for one vector load: accepts a start while idle, counts issued
// elements, and pulses done in the cycle after the last one.
// Assumes: can_issue_i reflects the target bank of the current address.
module sv_issue_sequencer
    import strided_issue_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             can_issue_i,
    output logic             load_o,
    output logic             issue_o,
    output logic             ready_o,
    output logic             done_o
);
    seq_state_t       state_q;
    logic [CNT_W-1:0] remain_q;
    logic             done_q;

    // Decode accept and issue from the state.
    always_comb begin
        ready_o = (state_q == SEQ_IDLE);
        load_o  = ready_o && start_i;
        issue_o = (state_q == SEQ_RUN) && can_issue_i;
    end

    // Track the remaining count and raise done after the final issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            remain_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_o) begin
                if (count_i == '0) begin
                    done_q <= 1'b1;
                end else begin
                    state_q  <= SEQ_RUN;
                    remain_q <= count_i;
                end
            end else if (issue_o) begin
                remain_q <= remain_q - 1'b1;
                if (remain_q == CNT_W'(1)) begin
                    state_q <= SEQ_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
endmodule

// File: rtl/strided_load_issuer.sv
// Top of the strided vector load issuer. Walks base + k*stride and sends
// one request per cycle to the bank picked by the low address bits, waiting
// while that bank is busy.
// Assumes: bank_busy_i is synchronous to clk.
module strided_load_issuer
    import strided_issue_pkg::*;
#(
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter int unsigned BANK_BITS = DEF_BANK_BITS,
    parameter int unsigned CNT_W     = DEF_CNT_W,
    localparam int unsigned NBANKS   = 1 << BANK_BITS,
    localparam int unsigned ROW_W    = ADDR_W - BANK_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [NBANKS-1:0] bank_busy_i,
    output logic              ready_o,
    output logic              issue_o,
    output logic [NBANKS-1:0] bank_en_o,
    output logic [ROW_W-1:0]  row_addr_o,
    output logic              done_o
);
    logic [ADDR_W-1:0]    addr_q;
    logic [ADDR_W-1:0]    stride_q;
    logic [BANK_BITS-1:0] bank_sel;
    logic                 can_issue;
    logic                 load;

    // Split the running address into bank number and in-bank address.
    always_comb begin
        bank_sel   = addr_q[BANK_BITS-1:0];
        can_issue  = !bank_busy_i[bank_sel];
        row_addr_o = issue_o ? addr_q[ADDR_W-1:BANK_BITS] : '0;
    end

    sv_issue_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .count_i     (count_i),
        .can_issue_i (can_issue),
        .load_o      (load),
        .issue_o     (issue_o),
        .ready_o     (ready_o),
        .done_o      (done_o)
    );

    sv_addr_walker #(.ADDR_W(ADDR_W)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .base_i   (base_i),
        .stride_i (stride_i),
        .step_i   (issue_o),
        .addr_o   (addr_q),
        .stride_o (stride_q)
    );

    sv_bank_decoder #(.SEL_W(BANK_BITS)) u_dec (
        .sel_i    (bank_sel),
        .enable_i (issue_o),
        .onehot_o (bank_en_o)
    );
endmodule

// File: rtl/strided_load_issuer_chk.sv
// Cycle-by-cycle properties of the strided vector load issuer, bound to it.
module strided_load_issuer_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned NBANKS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              ready_o,
    input logic              issue_o,
    input logic [NBANKS-1:0] bank_en_o,
    input logic [NBANKS-1:0] bank_busy_i,
    input logic              done_o,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [ADDR_W-1:0] cur_stride
);
    assert_onehot_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_en_o));

    assert_en_tracks_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o == (bank_en_o != '0));

    assert_no_busy_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_en_o & bank_busy_i) == '0);

    assert_stall_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && !issue_o) |=> $stable(cur_addr));

    assert_stride_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o |=> cur_addr == ADDR_W'($past(cur_addr) + $past(cur_stride)));

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && start_i) |=> $stable(cur_stride));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o);

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ready_o);
endmodule

bind strided_load_issuer strided_load_issuer_chk #(
    .ADDR_W (ADDR_W),
    .NBANKS (NBANKS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .ready_o     (ready_o),
    .issue_o     (issue_o),
    .bank_en_o   (bank_en_o),
    .bank_busy_i (bank_busy_i),
    .done_o      (done_o),
    .cur_addr    (addr_q),
    .cur_stride  (stride_q)
);

// File: tb/strided_load_issuer_tb.sv
// Sweeps base, stride, count and busy pattern; expectations are computed
// arithmetically from the requirements.
module strided_load_issuer_tb;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] base_i = '0;
    logic [ADDR_W-1:0] stride_i = '0;
    logic [CNT_W-1:0]  count_i = '0;
    logic [3:0]        bank_busy_i = '0;
    logic              ready_o, issue_o, done_o;
    logic [3:0]        bank_en_o;
    logic [13:0]       row_addr_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    strided_load_issuer u_dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .base_i (base_i),
        .stride_i (stride_i), .count_i (count_i), .bank_busy_i (bank_busy_i),
        .ready_o (ready_o), .issue_o (issue_o), .bank_en_o (bank_en_o),
        .row_addr_o (row_addr_o), .done_o (done_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // mode 0: no busy; mode 1: target busy on odd cycles, others busy on even;
    // mode 2: like mode 0 plus a stray start during the load.
    task automatic run_load(input logic [15:0] base, input logic [15:0] stride,
                            input int count, input int mode);
        logic [15:0] exp_addr;
        int k;
        int cyc;
        @(negedge clk);
        check("R1 ready before start", ready_o, 1);
        start_i = 1'b1; base_i = base; stride_i = stride; count_i = CNT_W'(count);
        @(negedge clk);
        start_i = 1'b0;
        exp_addr = base;
        k = 0;
        cyc = 0;
        if (count == 0) begin
            check("R8 no issue on zero count", issue_o, 0);
            check("R8 done after zero count", done_o, 1);
        end else begin
            check("R1 busy after accept", ready_o, 0);
            while (k < count && cyc < 4 * count + 4) begin
                if (mode == 1)
                    bank_busy_i = (cyc % 2 == 1) ? (4'b1 << exp_addr[1:0])
                                                 : ~(4'b1 << exp_addr[1:0]);
                else
                    bank_busy_i = '0;
                #1;
                if (mode == 1 && cyc % 2 == 1) begin
                    check("R5 stall on busy bank", issue_o, 0);
                    check("R5 no enable when stalled", bank_en_o, 0);
                    check("R4 row zero when idle", row_addr_o, 0);
                end else begin
                    check("R2 issue expected", issue_o, 1);
                    check("R3 bank one-hot", bank_en_o, 32'(4'b1 << exp_addr[1:0]));
                    check("R4 row address", row_addr_o, 32'(exp_addr >> 2));
                    check("R6 no early done", done_o, 0);
                    exp_addr = exp_addr + stride;
                    k++;
                end
                start_i = (mode == 2 && k < count);
                if (start_i) begin
                    base_i = ~base; stride_i = stride + 16'd7; count_i = 8'd9;
                end
                cyc++;
                @(negedge clk);
            end
            start_i = 1'b0;
            bank_busy_i = '0;
            #1;
            check("R6 done after last issue", done_o, 1);
            check("R6 ready with done", ready_o, 1);
            check("R7 no extra issue", issue_o, 0);
        end
        @(negedge clk);
        check("R6 done single pulse", done_o, 0);
        check("R6 stays idle", issue_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset ready", ready_o, 1);
        check("R9 reset issue", issue_o, 0);
        check("R9 reset done", done_o, 0);
        check("R9 reset enable", bank_en_o, 0);
        rst_n = 1'b1;
        // Column of a 4x3 row-major matrix.
        run_load(16'd1000, 16'd3, 4, 0);
        run_load(16'd0, 16'd0, 0, 0);
        for (int b = 0; b < 3; b++) begin
            for (int s = 0; s < 6; s++) begin
                for (int c = 1; c <= 5; c++) begin
                    for (int m = 0; m < 3; m++) begin
                        logic [15:0] bv;
                        logic [15:0] sv;
                        bv = (b == 0) ? 16'd0 : (b == 1) ? 16'd1000 : 16'hFFFE;
                        case (s)
                            0: sv = 16'd0;
                            1: sv = 16'd1;
                            2: sv = 16'd2;
                            3: sv = 16'd3;
                            4: sv = 16'd5;
                            default: sv = 16'hFFFF;
                        endcase
                        run_load(bv, sv, c, m);
                    end
                end
            end
        end
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule